// File: doc/BRIEF.md
# Operand Bypass Select Controller

This block sits beside the decode stage of a five-stage in-order pipeline. It looks at each instruction word held in decode, determines which architectural register that instruction will eventually write, and sends that destination number down the pipeline latches alongside the instruction. The register number moves forward one stage per clock and is held in three latches: decode/execute, execute/memory and memory/writeback.

In the same decode cycle it chooses the source for the second (lower) ALU operand that the instruction will use one clock later in execute. There are four choices: the register-file value, the result that will sit in the memory stage, the result that will sit in the writeback stage, or the sign-extended immediate. The choice is registered into the decode/execute latch. The comparison therefore runs one stage early, against the destinations of the two instructions ahead. The ALU, the register file, the multiplexer itself and any stall decision live elsewhere.

Top module: `bypsel_ctrl`

## Requirements
- R1: While `rst_n` is low, `idex_sel`, `idex_dst`, `exme_dst` and `mewb_dst` are all zero.
- R2: A register-form instruction has opcode (bits 31:26) 000000 and a function field (bits 5:0) other than 001000 or 001001. One clock after it is presented with `id_valid` high, `idex_dst` equals its bits 15:11.
- R3: A linking transfer is opcode 000011, or opcode 000000 with function 001001. One clock after it is presented, `idex_dst` equals 31.
- R4: The following leave `idex_dst` at 0 one clock later: a store (opcode 101xxx), a non-linking transfer (opcode 000010, opcode 0001xx, or opcode 000000 with function 001000), any other unlisted opcode, and any cycle with `id_valid` low. A cycle with `id_valid` low also leaves `idex_sel` at 0.
- R5: An immediate ALU instruction (opcode 001xxx) or a load (opcode 100xxx) yields `idex_dst` equal to its bits 20:16 one clock later.
- R6: For immediate ALU, load and store instructions, `idex_sel` is 3 (immediate) one clock later, whatever the register matches are.
- R7: For every other valid instruction, the source is bits 20:16. If the source is nonzero and equals the current `idex_dst`, `idex_sel` becomes 1 (memory-stage bypass). Otherwise, if it equals the current `exme_dst`, `idex_sel` becomes 2 (writeback-stage bypass). Otherwise it becomes 0 (register file). The nearer producer wins when both match.
- R8: A source of 0 never selects a bypass: `idex_sel` becomes 0 even when a later-stage destination is also 0.
- R9: On each clock, `exme_dst` takes the previous `idex_dst` and `mewb_dst` takes the previous `exme_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_insn | input | 32 | Instruction word in decode |
| idex_sel | output | 2 | Registered lower-operand select: 0 register, 1 memory bypass, 2 writeback bypass, 3 immediate |
| idex_dst | output | 5 | Destination in decode/execute latch (0 = no write) |
| exme_dst | output | 5 | Destination in execute/memory latch |
| mewb_dst | output | 5 | Destination in memory/writeback latch |

## Verification
The assertions assume that `id_insn` and `id_valid` are stable around each rising edge and that every bit pattern of the instruction word is legal input, so none of them constrains the opcode. The stimulus changes inputs only on the falling clock edge. It draws register numbers from the small range 0 to 3, so that nearby instructions often share a register and both bypass matches, including the zero-register case, occur frequently. Directed sequences add the double-match priority, a zero-destination producer followed by a zero-source reader, and idle cycles.

// File: rtl/bypsel_pkg.sv
package bypsel_pkg;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_REG   = 3'd1,
    K_IALU  = 3'd2,
    K_LOAD  = 3'd3,
    K_STORE = 3'd4,
    K_LINK  = 3'd5,
    K_CTRL  = 3'd6
  } insn_kind_e;

  typedef enum logic [1:0] {
    SEL_RFILE = 2'd0,
    SEL_MEFWD = 2'd1,
    SEL_WBFWD = 2'd2,
    SEL_IMM   = 2'd3
  } opb_sel_e;

  localparam int OPC_LSB = 26;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;

  // opcode and function field to instruction class
  function automatic insn_kind_e kind_of(input logic [OPC_W-1:0] opc,
                                         input logic [FN_W-1:0] fn);
    insn_kind_e k;
    k = K_NONE;
    if (opc == 6'b000000) begin
      if (fn == 6'b001001)      k = K_LINK;
      else if (fn == 6'b001000) k = K_CTRL;
      else                      k = K_REG;
    end else if (opc == 6'b000011)       k = K_LINK;
    else if (opc == 6'b000010)           k = K_CTRL;
    else if (opc[5:2] == 4'b0001)        k = K_CTRL;
    else if (opc[5:3] == 3'b001)         k = K_IALU;
    else if (opc[5:3] == 3'b100)         k = K_LOAD;
    else if (opc[5:3] == 3'b101)         k = K_STORE;
    return k;
  endfunction

  function automatic logic uses_imm(input insn_kind_e k);
    return (k == K_IALU) || (k == K_LOAD) || (k == K_STORE);
  endfunction

endpackage

// File: rtl/bypsel_decode.sv
module bypsel_decode
  import bypsel_pkg::*;
#(
  parameter int INSN_W   = 32,
  parameter int RAW      = 5,
  parameter int LINK_REG = 31
) (
  input  logic              valid,
  input  logic [INSN_W-1:0] insn,
  output insn_kind_e        kind,
  output logic [RAW-1:0]    dst,
  output logic [RAW-1:0]    src,
  output logic              imm_op
);

  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;
  logic [RAW-1:0]   f_rd;
  logic [RAW-1:0]   f_rt;

  assign opc  = insn[OPC_LSB +: OPC_W];
  assign fn   = insn[FN_W-1:0];
  assign f_rd = insn[RD_LSB +: RAW];
  assign f_rt = insn[RT_LSB +: RAW];

  assign kind   = valid ? kind_of(opc, fn) : K_NONE;
  assign src    = f_rt;
  assign imm_op = uses_imm(kind);

  always_comb begin
    case (kind)
      K_REG:          dst = f_rd;
      K_IALU, K_LOAD: dst = f_rt;
      K_LINK:         dst = RAW'(LINK_REG);
      default:        dst = '0;
    endcase
  end

endmodule

// File: rtl/bypsel_match.sv
module bypsel_match
  import bypsel_pkg::*;
#(
  parameter int RAW = 5
) (
  input  logic           valid,
  input  logic           imm_op,
  input  logic [RAW-1:0] src,
  input  logic [RAW-1:0] young_dst,
  input  logic [RAW-1:0] old_dst,
  output logic           hit_young,
  output logic           hit_old,
  output opb_sel_e       sel
);

  // register zero matches nothing
  assign hit_young = (src != '0) && (src == young_dst);
  assign hit_old   = (src != '0) && (src == old_dst);

  always_comb begin
    if (!valid)         sel = SEL_RFILE;
    else if (imm_op)    sel = SEL_IMM;
    else if (hit_young) sel = SEL_MEFWD;
    else if (hit_old)   sel = SEL_WBFWD;
    else                sel = SEL_RFILE;
  end

endmodule

// File: rtl/bypsel_dstpipe.sv
module bypsel_dstpipe #(
  parameter int RAW    = 5,
  parameter int STAGES = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [RAW-1:0]             d_in,
  output logic [STAGES-1:0][RAW-1:0] q
);

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [RAW-1:0] nxt;
      if (gi == 0) begin : g_head
        assign nxt = d_in;
      end else begin : g_tail
        assign nxt = q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[gi] <= '0;
        else        q[gi] <= nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/bypsel_ctrl.sv
module bypsel_ctrl
  import bypsel_pkg::*;
#(
  parameter int INSN_W   = 32,
  parameter int RAW      = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [INSN_W-1:0] id_insn,
  output logic [1:0]        idex_sel,
  output logic [RAW-1:0]    idex_dst,
  output logic [RAW-1:0]    exme_dst,
  output logic [RAW-1:0]    mewb_dst
);

  localparam int STAGES = 3;

  insn_kind_e                 w_kind;
  logic [RAW-1:0]             w_dst;
  logic [RAW-1:0]             w_src;
  logic                       w_imm_op;
  logic                       w_link;
  logic                       w_hit_young;
  logic                       w_hit_old;
  opb_sel_e                   w_sel_next;
  logic [STAGES-1:0][RAW-1:0] w_dq;
  opb_sel_e                   sel_q;

  bypsel_decode #(.INSN_W(INSN_W), .RAW(RAW), .LINK_REG(LINK_REG)) u_dec (
    .valid  (id_valid),
    .insn   (id_insn),
    .kind   (w_kind),
    .dst    (w_dst),
    .src    (w_src),
    .imm_op (w_imm_op)
  );

  assign w_link = (w_kind == K_LINK);

  bypsel_match #(.RAW(RAW)) u_match (
    .valid     (id_valid),
    .imm_op    (w_imm_op),
    .src       (w_src),
    .young_dst (w_dq[0]),
    .old_dst   (w_dq[1]),
    .hit_young (w_hit_young),
    .hit_old   (w_hit_old),
    .sel       (w_sel_next)
  );

  bypsel_dstpipe #(.RAW(RAW), .STAGES(STAGES)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (w_dst),
    .q     (w_dq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_RFILE;
    else        sel_q <= w_sel_next;
  end

  assign idex_sel = sel_q;
  assign idex_dst = w_dq[0];
  assign exme_dst = w_dq[1];
  assign mewb_dst = w_dq[2];

endmodule

// File: rtl/bypsel_ctrl_chk.sv
module bypsel_ctrl_chk #(
  parameter int RAW      = 5,
  parameter int LINK_REG = 31
) (
  input logic           clk,
  input logic           rst_n,
  input logic           id_valid,
  input logic [1:0]     idex_sel,
  input logic [RAW-1:0] idex_dst,
  input logic [RAW-1:0] exme_dst,
  input logic [RAW-1:0] mewb_dst,
  input logic [RAW-1:0] w_src,
  input logic           w_imm_op,
  input logic           w_link,
  input logic           w_hit_young
);

  // R1: outputs are zero while reset is held
  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (idex_sel == 2'd0 && idex_dst == '0 && exme_dst == '0 && mewb_dst == '0)
        else $error("reset values wrong");
    end
  end

  p_link_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && w_link) |=> (idex_dst == RAW'(LINK_REG)));

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> (idex_dst == '0 && idex_sel == 2'd0));

  p_imm_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && w_imm_op) |=> (idex_sel == 2'd3));

  p_young_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !w_imm_op && w_hit_young) |=> (idex_sel == 2'd1));

  p_zero_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !w_imm_op && w_src == '0) |=> (idex_sel == 2'd0));

  p_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exme_dst == $past(idex_dst)) && (mewb_dst == $past(exme_dst)));

endmodule

bind bypsel_ctrl bypsel_ctrl_chk #(.RAW(RAW), .LINK_REG(LINK_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .id_valid    (id_valid),
  .idex_sel    (idex_sel),
  .idex_dst    (idex_dst),
  .exme_dst    (exme_dst),
  .mewb_dst    (mewb_dst),
  .w_src       (w_src),
  .w_imm_op    (w_imm_op),
  .w_link      (w_link),
  .w_hit_young (w_hit_young)
);

// File: tb/bypsel_ctrl_test.sv
`timescale 1ns/1ps
module bypsel_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0;
  logic [31:0] id_insn = '0;
  logic [1:0]  idex_sel;
  logic [4:0]  idex_dst, exme_dst, mewb_dst;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  logic [4:0] m_d0 = '0, m_d1 = '0, m_d2 = '0;
  logic [1:0] m_sel = '0;
  string      tag_dst = "R1", tag_sel = "R1";

  always #2.5 clk = ~clk;

  bypsel_ctrl uut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_insn(id_insn),
    .idex_sel(idex_sel), .idex_dst(idex_dst), .exme_dst(exme_dst), .mewb_dst(mewb_dst)
  );

  // class codes: 0 none,1 reg,2 ialu,3 load,4 store,5 link,6 ctrl
  function automatic int cls(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [5:0] f = w[5:0];
    if (op == 0) return (f == 6'd9) ? 5 : (f == 6'd8) ? 6 : 1;
    if (op == 6'd3) return 5;
    if (op == 6'd2 || (op >= 6'd4 && op <= 6'd7)) return 6;
    if (op >= 6'd8 && op <= 6'd15) return 2;
    if (op >= 6'd32 && op <= 6'd39) return 3;
    if (op >= 6'd40 && op <= 6'd47) return 4;
    return 0;
  endfunction

  function automatic logic [4:0] want_dst(input logic v, input logic [31:0] w);
    if (!v) return 5'd0;
    case (cls(w))
      1: return w[15:11];
      2, 3: return w[20:16];
      5: return 5'd31;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [1:0] want_sel(input logic v, input logic [31:0] w,
                                          input logic [4:0] near, input logic [4:0] far);
    int c = cls(w);
    logic [4:0] s = w[20:16];
    if (!v) return 2'd0;
    if (c == 2 || c == 3 || c == 4) return 2'd3;
    if (s == 5'd0) return 2'd0;
    if (s == near) return 2'd1;
    if (s == far) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [4:0] rd,
                                     input logic [5:0] f);
    return {op, rs, rt, rd, 5'd0, f};
  endfunction

  function automatic logic [31:0] rnd_insn();
    logic [4:0] rs = 5'($urandom % 4);
    logic [4:0] rt = 5'($urandom % 4);
    logic [4:0] rd = 5'($urandom % 4);
    case ($urandom % 9)
      0, 1: return mk(6'd0, rs, rt, rd, 6'h20 + 6'($urandom % 8));
      2:    return mk(6'd8 + 6'($urandom % 8), rs, rt, rd, 6'($urandom));
      3:    return mk(6'd32 + 6'($urandom % 8), rs, rt, rd, 6'($urandom));
      4:    return mk(6'd40 + 6'($urandom % 8), rs, rt, rd, 6'($urandom));
      5:    return ($urandom % 2) ? mk(6'd3, rs, rt, rd, 6'($urandom)) : mk(6'd0, rs, rt, rd, 6'd9);
      6:    return ($urandom % 2) ? mk(6'd4 + 6'($urandom % 4), rs, rt, rd, 6'($urandom))
                                  : mk(6'd0, rs, rt, rd, 6'd8);
      7:    return mk(6'd48 + 6'($urandom % 16), rs, rt, rd, 6'($urandom));
      default: return mk(6'd0, rs, rt, rd, 6'h21);
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare outputs (at negedge) with model
  task automatic check_all();
    chk(tag_dst, "idex_dst", idex_dst, m_d0);
    chk(tag_sel, "idex_sel", idex_sel, m_sel);
    chk("R9", "exme_dst", exme_dst, m_d1);
    chk("R9", "mewb_dst", mewb_dst, m_d2);
  endtask

  // called at a negedge: drive one instruction and advance model
  task automatic issue(input logic v, input logic [31:0] w);
    int c = cls(w);
    logic [1:0] ns = want_sel(v, w, m_d0, m_d1);
    if (!v) tag_dst = "R4";
    else case (c)
      1: tag_dst = "R2";
      5: tag_dst = "R3";
      2, 3: tag_dst = "R5";
      default: tag_dst = "R4";
    endcase
    if (!v) tag_sel = "R4";
    else if (c == 2 || c == 3 || c == 4) tag_sel = "R6";
    else if (w[20:16] == 5'd0) tag_sel = "R8";
    else tag_sel = "R7";
    m_d2 = m_d1;
    m_d1 = m_d0;
    m_d0 = want_dst(v, w);
    m_sel = ns;
    id_valid = v;
    id_insn = w;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    id_insn = mk(6'd0, 5'd1, 5'd2, 5'd3, 6'h20);
    id_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero despite active input
    chk("R1", "idex_sel", idex_sel, 0);
    chk("R1", "idex_dst", idex_dst, 0);
    chk("R1", "exme_dst", exme_dst, 0);
    chk("R1", "mewb_dst", mewb_dst, 0);
    id_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R2 then R7: register-form producer of r5, consumer reads r5 next
    issue(1'b1, mk(6'd0, 5'd1, 5'd2, 5'd5, 6'h20));
    issue(1'b1, mk(6'd0, 5'd7, 5'd5, 5'd6, 6'h22));
    // writeback bypass: r5 now two ahead, r6 one ahead
    issue(1'b1, mk(6'd0, 5'd0, 5'd5, 5'd9, 6'h20));
    // R7 priority: both ahead write r4
    issue(1'b1, mk(6'd9, 5'd0, 5'd4, 5'd0, 6'd0));
    issue(1'b1, mk(6'd0, 5'd1, 5'd2, 5'd4, 6'h20));
    issue(1'b1, mk(6'd0, 5'd1, 5'd4, 5'd8, 6'h20));
    // R6: immediate op reading a just-written register still picks immediate
    issue(1'b1, mk(6'd35, 5'd8, 5'd10, 5'd0, 6'd0));
    issue(1'b1, mk(6'd43, 5'd0, 5'd10, 5'd0, 6'd0));
    // R8: store (dest 0) ahead, then reader of r0
    issue(1'b1, mk(6'd0, 5'd0, 5'd0, 5'd3, 6'h20));
    // R3: both linking forms, then reader of r31
    issue(1'b1, mk(6'd3, 5'd0, 5'd0, 5'd0, 6'd0));
    issue(1'b1, mk(6'd0, 5'd2, 5'd0, 5'd12, 6'd9));
    issue(1'b1, mk(6'd0, 5'd2, 5'd31, 5'd1, 6'h20));
    // R4: non-linking transfers, unknown opcode, idle
    issue(1'b1, mk(6'd0, 5'd31, 5'd0, 5'd0, 6'd8));
    issue(1'b1, mk(6'd5, 5'd1, 5'd2, 5'd3, 6'd0));
    issue(1'b1, mk(6'd50, 5'd1, 5'd2, 5'd3, 6'd0));
    issue(1'b0, mk(6'd0, 5'd1, 5'd2, 5'd3, 6'h20));

    for (int i = 0; i < 3000; i++) begin
      issue(($urandom % 8) != 0, rnd_insn());
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule